// File: doc/BRIEF.md
# I2C Output Port Slave

This block is a two-wire bus slave that owns one 8-bit control register and turns each register bit into a pull-low enable for one output pin. A bus master addresses the slave, then either writes a new pattern for the eight pins or reads back the pattern currently in force. Each pin enable drives an open-drain pad. A 1 in the enable pulls the pin low, which for example lights an LED. A 0 leaves the pad in high impedance. The slave's own SDA output is also an enable: when it is 1, the pad pulls the bus line low.

SCL and SDA arrive without a clock relation to the system. They are oversampled through two-flop synchronizers, and the START and STOP conditions are found from the sampled edges. A written byte first lands in a shadow register. It moves to the pins only when the master closes the transfer with STOP. This lets a whole pin pattern change at one instant, and a transfer that is abandoned part-way leaves the pins as they were.

Top module: `outport_slave`

## Requirements
- R1: The slave answers the 7-bit address whose upper four bits are 1100 and whose lower three bits are `strap[2:0]`, with `strap[2]` as address bit 2. The eighth bit of the address byte is the direction: 0 means write and 1 means read. On a match the slave pulls SDA low during the ninth clock.
- R2: When the address does not match, the slave never pulls SDA low and the outputs do not change. This holds until the next START.
- R3: In a write, the slave takes one data byte MSB first and acknowledges it. Byte bit i controls output i.
- R4: The output pins stay unchanged after the data byte is acknowledged. They take the written value only when a STOP condition follows.
- R5: `portPullLow[i]` = 1 when register bit i is 1, which pulls the pin low. It is 0 when the bit is 0, leaving the pin in high impedance.
- R6: In a read, after acknowledging the address, the slave drives the current register value MSB first. It then releases SDA for the master's acknowledge bit. A NACK followed by STOP ends the transfer.
- R7: While the asynchronous active-low reset `rstN` is low, the register is all zeros, every output is off and SDA is released. After reset the slave waits idle for a START, and any write still pending before the reset is lost.
- R8: A START or repeated START at any point abandons the transfer in progress and restarts address reception. A write cut off this way never reaches the outputs.
- R9: Additional data bytes in one write are each acknowledged and each overwrites the shadow register. Only the last one is committed at STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Sampled bus clock line |
| sdaIn | input | 1 | Sampled bus data line (wired level) |
| strap | input | 3 | Lower three address bits |
| sdaPullLow | output | 1 | 1 = drive SDA low, 0 = release |
| portPullLow | output | 8 | Per-pin pull-low enable, 1 = sinking |

## Verification
The bench first walks a set of writes with matching and non-matching addresses, reading back the register after each one. It then targets the places where a careless design commits too early. Outputs are sampled between the data acknowledge and STOP: a design that commits at the acknowledge shows the new value there. Writes are abandoned by a repeated START and by a reset: a design that keeps a stale pending flag would then commit data nobody confirmed. Writes of several bytes check that only the last byte reaches the pins. Changing the straps checks that the old address goes quiet rather than still being acknowledged.

// File: rtl/outport_pkg.sv
package outport_pkg;

  // Strobes from bus control to the register datapath
  typedef struct packed {
    logic shiftIn;        // shift received bit into shift register
    logic rxBit;          // value of the received bit
    logic loadTx;         // load control register for transmission
    logic shiftTx;        // advance transmit shift register
    logic captureShadow;  // copy shift register into shadow
    logic commit;         // copy shadow into control register
  } dpCmd_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WDATA,
    ST_WACK,
    ST_RDATA,
    ST_RACK,
    ST_IGNORE
  } slvState_t;

endpackage

// File: rtl/outport_ctrl.sv
module outport_ctrl
  import outport_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   sclIn,
  input  logic   sdaIn,
  input  logic   addrMatch,
  input  logic   rwBit,
  input  logic   txBit,
  output dpCmd_t cmd,
  output logic   sdaPullLow
);

  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_W - 1);

  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
  logic sclPrev, sdaPrev;
  logic sclNow, sdaNow;
  logic sclRise, sclFall, startDet, stopDet;

  slvState_t state, stateNxt;
  logic [CNT_W-1:0] cnt, cntNxt;
  logic wrPending, pendNxt;
  logic masterAck, mAckNxt;

  // Two-flop (or deeper) synchronizers, idle bus level is high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclPipe[SYNC_STAGES-1];
      sdaPrev <= sdaPipe[SYNC_STAGES-1];
    end
  end

  assign sclNow   = sclPipe[SYNC_STAGES-1];
  assign sdaNow   = sdaPipe[SYNC_STAGES-1];
  assign sclRise  = sclNow & ~sclPrev;
  assign sclFall  = ~sclNow & sclPrev;
  assign startDet = sclNow & sclPrev & sdaPrev & ~sdaNow;
  assign stopDet  = sclNow & sclPrev & ~sdaPrev & sdaNow;

  always_comb begin
    stateNxt  = state;
    cntNxt    = cnt;
    pendNxt   = wrPending;
    mAckNxt   = masterAck;
    cmd       = '0;
    cmd.rxBit = sdaNow;
    if (startDet) begin
      stateNxt = ST_ADDR;
      cntNxt   = '0;
      pendNxt  = 1'b0;
    end else if (stopDet) begin
      cmd.commit = wrPending;
      pendNxt    = 1'b0;
      stateNxt   = ST_IDLE;
    end else begin
      case (state)
        ST_ADDR: begin
          if (sclRise) begin
            cmd.shiftIn = 1'b1;
            cntNxt      = cnt + CNT_W'(1);
          end else if (sclFall && cnt == CNT_FULL) begin
            cntNxt   = '0;
            stateNxt = addrMatch ? ST_AACK : ST_IGNORE;
          end
        end
        ST_AACK: begin
          if (sclFall) begin
            if (rwBit) begin
              stateNxt   = ST_RDATA;
              cmd.loadTx = 1'b1;
            end else begin
              stateNxt = ST_WDATA;
            end
          end
        end
        ST_WDATA: begin
          if (sclRise) begin
            cmd.shiftIn = 1'b1;
            cntNxt      = cnt + CNT_W'(1);
          end else if (sclFall && cnt == CNT_FULL) begin
            cmd.captureShadow = 1'b1;
            pendNxt           = 1'b1;
            cntNxt            = '0;
            stateNxt          = ST_WACK;
          end
        end
        ST_WACK: begin
          if (sclFall) stateNxt = ST_WDATA;
        end
        ST_RDATA: begin
          if (sclFall) begin
            if (cnt == CNT_LAST) begin
              cntNxt   = '0;
              stateNxt = ST_RACK;
            end else begin
              cmd.shiftTx = 1'b1;
              cntNxt      = cnt + CNT_W'(1);
            end
          end
        end
        ST_RACK: begin
          if (sclRise) begin
            mAckNxt = ~sdaNow;
          end else if (sclFall) begin
            if (masterAck) begin
              stateNxt   = ST_RDATA;
              cmd.loadTx = 1'b1;
            end else begin
              stateNxt = ST_IGNORE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      wrPending <= 1'b0;
      masterAck <= 1'b0;
    end else begin
      state     <= stateNxt;
      cnt       <= cntNxt;
      wrPending <= pendNxt;
      masterAck <= mAckNxt;
    end
  end

  always_comb begin
    case (state)
      ST_AACK, ST_WACK: sdaPullLow = 1'b1;
      ST_RDATA:         sdaPullLow = ~txBit;
      default:          sdaPullLow = 1'b0;
    endcase
  end

  // R2
  no_drive_when_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE || state == ST_IGNORE) |-> !sdaPullLow);

  // R8
  start_restarts_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    startDet |=> (state == ST_ADDR && cnt == '0));

  // R4
  stop_returns_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> (state == ST_IDLE && !wrPending));

endmodule

// File: rtl/outport_dp.sv
module outport_dp
  import outport_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 7,
  parameter int STRAP_W = 3,
  parameter logic [ADDR_W-STRAP_W-1:0] FIXED_HI = 4'b1100
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [STRAP_W-1:0] strap,
  input  dpCmd_t             cmd,
  output logic               addrMatch,
  output logic               rwBit,
  output logic               txBit,
  output logic [DATA_W-1:0]  portPullLow
);

  logic [DATA_W-1:0] shiftReg;
  logic [DATA_W-1:0] shadowReg;
  logic [DATA_W-1:0] ctrlReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (cmd.loadTx) begin
      shiftReg <= ctrlReg;
    end else if (cmd.shiftIn) begin
      shiftReg <= {shiftReg[DATA_W-2:0], cmd.rxBit};
    end else if (cmd.shiftTx) begin
      shiftReg <= {shiftReg[DATA_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shadowReg <= '0;
    else if (cmd.captureShadow) shadowReg <= shiftReg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ctrlReg <= '0;
    else if (cmd.commit) ctrlReg <= shadowReg;
  end

  assign addrMatch   = (shiftReg[ADDR_W:1] == {FIXED_HI, strap});
  assign rwBit       = shiftReg[0];
  assign txBit       = shiftReg[DATA_W-1];
  assign portPullLow = ctrlReg;

  // R4
  reg_changes_only_on_commit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlReg != $past(ctrlReg)) |-> $past(cmd.commit));

endmodule

// File: rtl/outport_slave.sv
module outport_slave
  import outport_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 7,
  parameter int STRAP_W     = 3,
  parameter int SYNC_STAGES = 2,
  parameter logic [ADDR_W-STRAP_W-1:0] FIXED_HI = 4'b1100
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sclIn,
  input  logic               sdaIn,
  input  logic [STRAP_W-1:0] strap,
  output logic               sdaPullLow,
  output logic [DATA_W-1:0]  portPullLow
);

  dpCmd_t cmd;
  logic addrMatch, rwBit, txBit;

  outport_ctrl #(
    .DATA_W     (DATA_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .sclIn     (sclIn),
    .sdaIn     (sdaIn),
    .addrMatch (addrMatch),
    .rwBit     (rwBit),
    .txBit     (txBit),
    .cmd       (cmd),
    .sdaPullLow(sdaPullLow)
  );

  outport_dp #(
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W),
    .STRAP_W (STRAP_W),
    .FIXED_HI(FIXED_HI)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strap      (strap),
    .cmd        (cmd),
    .addrMatch  (addrMatch),
    .rwBit      (rwBit),
    .txBit      (txBit),
    .portPullLow(portPullLow)
  );

endmodule

// File: tb/outport_slave_tb_top.sv
module outport_slave_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int QTR = 8;  // clocks per quarter bit

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic [2:0] strap = 3'b101;
  logic sdaPullLow;
  logic [7:0] portPullLow;
  logic sdaLine;

  int nChecks = 0;
  int nFails = 0;

  assign sdaLine = sdaM & ~sdaPullLow;

  always #(CLK_PERIOD/2) clk = ~clk;

  outport_slave dut_i (
    .clk        (clk),
    .rstN       (rstN),
    .sclIn      (sclM),
    .sdaIn      (sdaLine),
    .strap      (strap),
    .sdaPullLow (sdaPullLow),
    .portPullLow(portPullLow)
  );

  // {addrByte, dataByte, expAck, expPorts}; strap = 101 -> write addr CA
  localparam logic [24:0] VEC [6] = '{
    {8'hCA, 8'hC1, 1'b0, 8'hC1},
    {8'hCA, 8'h00, 1'b0, 8'h00},
    {8'hCA, 8'hA5, 1'b0, 8'hA5},
    {8'hC8, 8'h3C, 1'b1, 8'hA5},
    {8'h4A, 8'hFF, 1'b1, 8'hA5},
    {8'hCA, 8'h7E, 1'b0, 8'h7E}
  };

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic waitQ();
    repeat (QTR) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; sclM = 1'b1; waitQ();
    sdaM = 1'b0; waitQ();
    sclM = 1'b0; waitQ();
  endtask

  task automatic busRestart();
    sdaM = 1'b1; waitQ();
    sclM = 1'b1; waitQ();
    sdaM = 1'b0; waitQ();
    sclM = 1'b0; waitQ();
  endtask

  task automatic busStop();
    sdaM = 1'b0; waitQ();
    sclM = 1'b1; waitQ();
    sdaM = 1'b1; waitQ();
  endtask

  task automatic busBit(input logic b, output logic r);
    sdaM = b; waitQ();
    sclM = 1'b1; waitQ();
    r = sdaLine; waitQ();
    sclM = 1'b0; waitQ();
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    logic dummy;
    for (int i = 7; i >= 0; i--) busBit(b[i], dummy);
    busBit(1'b1, ack);
  endtask

  task automatic readByte(output logic [7:0] d, input logic giveAck);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      busBit(1'b1, r);
      d[i] = r;
    end
    busBit(~giveAck, r);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] rd;
    logic [7:0] prevPorts;

    repeat (5) @(negedge clk);
    // R7 reset state
    chk(portPullLow, 8'h00, "R7 reset ports");
    chk({7'b0, sdaPullLow}, 8'h00, "R7 reset sda");
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    prevPorts = 8'h00;

    // Table walk: write, check pre-STOP hold, commit, read back
    for (int v = 0; v < 6; v++) begin
      busStart();
      sendByte(VEC[v][24:17], ack);
      chk({7'b0, ack}, {7'b0, VEC[v][8]}, "R1/R2 address ack");
      sendByte(VEC[v][16:9], ack);
      chk({7'b0, ack}, {7'b0, VEC[v][8]}, "R3/R2 data ack");
      chk(portPullLow, prevPorts, "R4 hold before stop");
      busStop();
      repeat (4) @(negedge clk);
      chk(portPullLow, VEC[v][7:0], "R5 ports after stop");
      prevPorts = VEC[v][7:0];
      busStart();
      sendByte(8'hCB, ack);
      chk({7'b0, ack}, 8'h00, "R6 read address ack");
      readByte(rd, 1'b0);
      chk(rd, VEC[v][7:0], "R6 read data");
      busStop();
      repeat (4) @(negedge clk);
      chk({7'b0, sdaPullLow}, 8'h00, "R6 sda released");
    end

    // R8: write aborted by repeated START, then read
    busStart();
    sendByte(8'hCA, ack);
    sendByte(8'h55, ack);
    chk({7'b0, ack}, 8'h00, "R8 data ack");
    busRestart();
    sendByte(8'hCB, ack);
    chk({7'b0, ack}, 8'h00, "R8 restart address ack");
    readByte(rd, 1'b0);
    chk(rd, 8'h7E, "R8 aborted write not visible");
    busStop();
    repeat (4) @(negedge clk);
    chk(portPullLow, 8'h7E, "R8 ports unchanged");

    // R9: multi-byte write, last byte wins
    busStart();
    sendByte(8'hCA, ack);
    sendByte(8'h11, ack);
    chk({7'b0, ack}, 8'h00, "R9 byte1 ack");
    sendByte(8'h22, ack);
    chk({7'b0, ack}, 8'h00, "R9 byte2 ack");
    sendByte(8'h33, ack);
    chk({7'b0, ack}, 8'h00, "R9 byte3 ack");
    chk(portPullLow, 8'h7E, "R9 hold before stop");
    busStop();
    repeat (4) @(negedge clk);
    chk(portPullLow, 8'h33, "R9 last byte committed");

    // R1: strap change moves the address
    strap = 3'b010;
    repeat (4) @(negedge clk);
    busStart();
    sendByte(8'hCA, ack);
    chk({7'b0, ack}, 8'h01, "R2 old address ignored");
    busStop();
    busStart();
    sendByte(8'hC4, ack);
    chk({7'b0, ack}, 8'h00, "R1 new strap address ack");
    sendByte(8'h0F, ack);
    busStop();
    repeat (4) @(negedge clk);
    chk(portPullLow, 8'h0F, "R1 write via new strap");

    // R7: reset in the middle of a write
    busStart();
    sendByte(8'hC4, ack);
    sendByte(8'hF0, ack);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    chk(portPullLow, 8'h00, "R7 reset clears ports");
    chk({7'b0, sdaPullLow}, 8'h00, "R7 reset releases sda");
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    busStop();
    repeat (4) @(negedge clk);
    chk(portPullLow, 8'h00, "R7 pending write lost");
    busStart();
    sendByte(8'hC4, ack);
    sendByte(8'h99, ack);
    busStop();
    repeat (4) @(negedge clk);
    chk(portPullLow, 8'h99, "R7 idle after reset");

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule